// File: doc/BRIEF.md
# Event Ring Record Writer

This block turns fault and event reports from an address-translation unit into fixed-format records in a circular ring held in system memory. Each accepted report becomes eight 32-bit words (32 bytes). The block writes them one at a time through a simple valid/ready memory write port. Software drains the ring and moves a consumer index forward through a register write. The block publishes a producer register that holds the wrapped producer index and an overflow flag.

Ring size is chosen at run time as a power of two, from 1 to 2^MAX_LOG2 records. Each index carries one extra wrap bit above the slot bits. The ring is full when the two indices agree in their slot bits and differ in the wrap bit.

A report that arrives while the ring is full is never stalled. It is discarded, and the overflow flag is flipped so software can see that records were lost. While a record is being written, the producer index does not move. It advances only once memory has taken the last word of the record. A one-cycle interrupt pulse can then be raised.

Top module: `evt_ring_writer`

## Requirements
- R1: After reset the producer register reads 0, `irq` is low, `mem_wvalid` is low and `ev_ready` is high.
- R2: Record word 0 is {ssid[19:0] in bits 31:12, ssv in bit 11, zeros in bits 10:8, event code in bits 7:0}. Word 1 is the 32-bit stream ID.
- R3: Record word 2 holds the stall flag in bit 31 and the stall tag in bits 15:0. Word 3 holds the fault class in bits 9:8, the stage-2 flag in bit 7, read-not-write in bit 3, InD in bit 2 and PnU in bit 1. All other bits of words 2 and 3 are zero.
- R4: Words 4 and 5 hold the first 64-bit address, bits 31:0 then bits 63:32. Words 6 and 7 hold the second address in the same order.
- R5: Word k of a record goes to address (cfg_base & 0x000F_FFFF_FFFF_FFC0) + 32*slot + 4*k. Words go out in order 0 to 7. Address and data hold steady while `mem_wready` is low.
- R6: The producer index (bits IDX_W-1:0 of `prod_reg`) advances by one, modulo 2^(log2size+1). It does so on the edge where memory accepts word 7, and at no earlier point.
- R7: A report accepted while the ring is full writes nothing and leaves the producer index unchanged. It flips bit 31 of `prod_reg`.
- R8: While `queue_en` is low, a report is accepted and discarded. Nothing is written and `prod_reg` is unchanged.
- R9: When `irq_en` is high, `irq` is high for exactly the one cycle after a record is completed. Dropped reports and records completed with `irq_en` low raise no interrupt.
- R10: A write of `cons_wdata` with `cons_wr` replaces the consumer index, masked to log2size+1 bits. This can turn a full ring into one with free space.
- R11: `ev_ready` is high only when no record is in flight.
- R12: A `cfg_log2size` above MAX_LOG2 is treated as MAX_LOG2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| queue_en | input | 1 | Ring enable; records are written only while high |
| irq_en | input | 1 | Interrupt enable |
| cfg_base | input | 64 | Ring base address (masked internally) |
| cfg_log2size | input | LG_W | log2 of ring size in records |
| cons_wr | input | 1 | Consumer index write strobe |
| cons_wdata | input | IDX_W | New consumer index with wrap bit |
| ev_valid | input | 1 | Report valid |
| ev_ready | output | 1 | Report accepted when high with ev_valid |
| ev_code | input | 8 | Event type code |
| ev_sid | input | 32 | Stream ID |
| ev_ssid | input | 20 | Substream ID |
| ev_ssv | input | 1 | Substream ID valid |
| ev_stag | input | 16 | Stall tag |
| ev_stall | input | 1 | Stall flag |
| ev_pnu | input | 1 | Privileged/unprivileged attribute |
| ev_ind | input | 1 | Instruction/data attribute |
| ev_rnw | input | 1 | Read-not-write |
| ev_s2 | input | 1 | Fault came from stage 2 |
| ev_class | input | 2 | Fault class |
| ev_addr | input | 64 | Input address |
| ev_addr2 | input | 64 | Second address |
| mem_wvalid | output | 1 | Memory write request |
| mem_waddr | output | 64 | Byte address of the word |
| mem_wdata | output | 32 | Word data |
| mem_wready | input | 1 | Memory accepts the word |
| prod_reg | output | 32 | {overflow, zeros, producer index} |
| irq | output | 1 | Record-complete interrupt pulse |

## Verification
A report is taken on the rising edge where `ev_valid` and `ev_ready` are both high. Word 0 is on the memory port in the following cycle. A drop updates bit 31 of `prod_reg` on that same accepting edge. For a written record, `prod_reg` changes on the edge that accepts word 7, and `irq` is high for the cycle after that edge, so the record takes eight or more cycles depending on how memory stalls.

The bench drives and samples only on falling edges. It captures each word on the falling edge before the edge that accepts it. After a report, it waits for the falling edge on which `ev_ready` is back high, then waits one more falling edge before comparing the producer register, the write count, the interrupt count and the stored words. One record is deliberately stalled, and its in-flight state is checked in the middle of the stall.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int WORD_W    = 32;
  localparam int REC_WORDS = 8;
  localparam int REC_SHIFT = $clog2(REC_WORDS * WORD_W / 8);
  localparam logic [63:0] BASE_KEEP = 64'h000F_FFFF_FFFF_FFC0;

  typedef struct packed {
    logic [7:0]  code;
    logic [31:0] sid;
    logic [19:0] ssid;
    logic        ssv;
    logic [15:0] stag;
    logic        stall;
    logic        pnu;
    logic        ind;
    logic        rnw;
    logic        s2;
    logic [1:0]  cls;
    logic [63:0] addr;
    logic [63:0] addr2;
  } evq_event_t;

  typedef enum logic {SND_IDLE, SND_BUSY} snd_state_e;
endpackage

// File: rtl/evq_rec_pack.sv
module evq_rec_pack
  import evq_pkg::*;
(
  input  evq_event_t                          ev,
  output logic [REC_WORDS-1:0][WORD_W-1:0]    words
);
  always_comb begin
    words    = '0;
    words[0] = {ev.ssid, ev.ssv, 3'b000, ev.code};
    words[1] = ev.sid;
    words[2] = {ev.stall, 15'd0, ev.stag};
    words[3] = {22'd0, ev.cls, ev.s2, 3'b000, ev.rnw, ev.ind, ev.pnu, 1'b0};
    words[4] = ev.addr[31:0];
    words[5] = ev.addr[63:32];
    words[6] = ev.addr2[31:0];
    words[7] = ev.addr2[63:32];
  end
endmodule

// File: rtl/evq_ring_ptrs.sv
module evq_ring_ptrs #(
  parameter int IDX_W = 9,
  parameter int LG_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LG_W-1:0]  lg,
  input  logic             cons_wr,
  input  logic [IDX_W-1:0] cons_wdata,
  input  logic             commit,
  input  logic             drop,
  output logic             full,
  output logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] slot,
  output logic             ovf
);
  logic [IDX_W-1:0] wrap_bit, wrap_idx_mask, idx_mask;
  logic [IDX_W-1:0] prod_q, prod_d, cons_q, cons_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    wrap_bit      = IDX_W'(1) << lg;
    wrap_idx_mask = (wrap_bit << 1) - IDX_W'(1);
    idx_mask      = wrap_bit - IDX_W'(1);
    full          = ((cons_q ^ prod_q) & wrap_idx_mask) == wrap_bit;
  end

  always_comb begin
    prod_d = prod_q;
    cons_d = cons_q;
    ovf_d  = ovf_q;
    if (commit)  prod_d = (prod_q + IDX_W'(1)) & wrap_idx_mask;
    if (drop)    ovf_d  = ~ovf_q;
    if (cons_wr) cons_d = cons_wdata & wrap_idx_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (commit)  prod_q <= prod_d;
      if (cons_wr) cons_q <= cons_d;
      if (drop)    ovf_q  <= ovf_d;
    end
  end

  assign prod_idx = prod_q;
  assign slot     = prod_q & idx_mask;
  assign ovf      = ovf_q;

  // R7: a drop flips the flag and keeps the producer index
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (ovf_q != $past(ovf_q)) && (prod_q == $past(prod_q)));
endmodule

// File: rtl/evq_word_sender.sv
module evq_word_sender
  import evq_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             take,
  input  logic [REC_WORDS-1:0][WORD_W-1:0] words_in,
  input  logic [63:0]                      rec_base,
  output logic                             ev_ready,
  output logic                             mem_wvalid,
  output logic [63:0]                      mem_waddr,
  output logic [WORD_W-1:0]                mem_wdata,
  input  logic                             mem_wready,
  output logic                             commit
);
  localparam int CNT_W = $clog2(REC_WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_WORDS - 1);

  snd_state_e                       state_q, state_d;
  logic [CNT_W-1:0]                 cnt_q, cnt_d;
  logic [REC_WORDS-1:0][WORD_W-1:0] words_q;
  logic [63:0]                      base_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    commit  = 1'b0;
    case (state_q)
      SND_IDLE: if (take) begin
        state_d = SND_BUSY;
        cnt_d   = '0;
      end
      SND_BUSY: if (mem_wready) begin
        if (cnt_q == LAST) begin
          state_d = SND_IDLE;
          cnt_d   = '0;
          commit  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = SND_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SND_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      words_q <= words_in;
      base_q  <= rec_base;
    end
  end

  assign ev_ready   = (state_q == SND_IDLE);
  assign mem_wvalid = (state_q == SND_BUSY);
  assign mem_waddr  = base_q + 64'({cnt_q, 2'b00});
  assign mem_wdata  = words_q[cnt_q];

  // R5: a stalled word holds address and data
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata));
  // R11: no new report while a record is in flight
  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !ev_ready);
endmodule

// File: rtl/evt_ring_writer.sv
module evt_ring_writer
  import evq_pkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int LG_W     = $clog2(MAX_LOG2 + 1),
  parameter int IDX_W    = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              queue_en,
  input  logic              irq_en,
  input  logic [63:0]       cfg_base,
  input  logic [LG_W-1:0]   cfg_log2size,
  input  logic              cons_wr,
  input  logic [IDX_W-1:0]  cons_wdata,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [7:0]        ev_code,
  input  logic [31:0]       ev_sid,
  input  logic [19:0]       ev_ssid,
  input  logic              ev_ssv,
  input  logic [15:0]       ev_stag,
  input  logic              ev_stall,
  input  logic              ev_pnu,
  input  logic              ev_ind,
  input  logic              ev_rnw,
  input  logic              ev_s2,
  input  logic [1:0]        ev_class,
  input  logic [63:0]       ev_addr,
  input  logic [63:0]       ev_addr2,
  output logic              mem_wvalid,
  output logic [63:0]       mem_waddr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_wready,
  output logic [31:0]       prod_reg,
  output logic              irq
);
  evq_event_t                       ev;
  logic [REC_WORDS-1:0][WORD_W-1:0] words;
  logic [LG_W-1:0]                  lg;
  logic [IDX_W-1:0]                 prod_idx, slot;
  logic [63:0]                      base_m, rec_base;
  logic full, ovf, accept, take, drop, commit, irq_q;

  assign lg = (cfg_log2size > LG_W'(MAX_LOG2)) ? LG_W'(MAX_LOG2) : cfg_log2size;

  assign ev = '{code: ev_code, sid: ev_sid, ssid: ev_ssid, ssv: ev_ssv,
                stag: ev_stag, stall: ev_stall, pnu: ev_pnu, ind: ev_ind,
                rnw: ev_rnw, s2: ev_s2, cls: ev_class, addr: ev_addr,
                addr2: ev_addr2};

  assign accept   = ev_valid && ev_ready;
  assign take     = accept && queue_en && !full;
  assign drop     = accept && queue_en && full;
  assign base_m   = cfg_base & BASE_KEEP;
  assign rec_base = base_m + (64'(slot) << REC_SHIFT);

  evq_rec_pack u_pack (.ev(ev), .words(words));

  evq_ring_ptrs #(.IDX_W(IDX_W), .LG_W(LG_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .lg(lg), .cons_wr(cons_wr),
    .cons_wdata(cons_wdata), .commit(commit), .drop(drop), .full(full),
    .prod_idx(prod_idx), .slot(slot), .ovf(ovf));

  evq_word_sender u_send (
    .clk(clk), .rst_n(rst_n), .take(take), .words_in(words),
    .rec_base(rec_base), .ev_ready(ev_ready), .mem_wvalid(mem_wvalid),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wready(mem_wready),
    .commit(commit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= commit && irq_en;
  end

  assign irq      = irq_q;
  assign prod_reg = {ovf, {(31 - IDX_W){1'b0}}, prod_idx};

  // R9: an interrupt only follows a producer advance
  assert_irq_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (prod_idx != $past(prod_idx)));
  // R6: the producer index moves only on a completed record
  assert_prod_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_idx != $past(prod_idx)) |-> $past(commit));
  // R5: writes stay inside the ring window
  assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && $stable(cfg_base) |->
      ((mem_waddr - base_m) >> REC_SHIFT) < (64'd1 << lg));
endmodule

// File: tb/sim_evt_ring_writer.sv
module sim_evt_ring_writer;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 9;
  localparam int LG_W  = 4;
  localparam logic [63:0] BASE_RAW = 64'hFFF0_0000_8000_102B;
  localparam logic [63:0] BASE_M   = 64'h0000_0000_8000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic queue_en = 0, irq_en = 0, cons_wr = 0, ev_valid = 0, mem_wready = 0;
  logic [63:0] cfg_base = BASE_RAW;
  logic [LG_W-1:0] cfg_log2size = 4'd2;
  logic [IDX_W-1:0] cons_wdata = '0;
  logic [7:0] t_code = 0; logic [31:0] t_sid = 0; logic [19:0] t_ssid = 0;
  logic t_ssv = 0, t_stall = 0, t_pnu = 0, t_ind = 0, t_rnw = 0, t_s2 = 0;
  logic [15:0] t_stag = 0; logic [1:0] t_cls = 0;
  logic [63:0] t_addr = 0, t_addr2 = 0;
  logic ev_ready, mem_wvalid, irq;
  logic [63:0] mem_waddr; logic [31:0] mem_wdata, prod_reg;

  evt_ring_writer #(.MAX_LOG2(8)) u0 (
    .clk(clk), .rst_n(rst_n), .queue_en(queue_en), .irq_en(irq_en),
    .cfg_base(cfg_base), .cfg_log2size(cfg_log2size), .cons_wr(cons_wr),
    .cons_wdata(cons_wdata), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(t_code), .ev_sid(t_sid), .ev_ssid(t_ssid), .ev_ssv(t_ssv),
    .ev_stag(t_stag), .ev_stall(t_stall), .ev_pnu(t_pnu), .ev_ind(t_ind),
    .ev_rnw(t_rnw), .ev_s2(t_s2), .ev_class(t_cls), .ev_addr(t_addr),
    .ev_addr2(t_addr2), .mem_wvalid(mem_wvalid), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_wready(mem_wready), .prod_reg(prod_reg),
    .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0, wr_count = 0, irq_count = 0, cyc = 0;
  bit hold_ready = 0, bad_addr = 0;
  logic [31:0] mem_model [512];
  logic [IDX_W-1:0] m_prod = 0, m_cons = 0;
  bit m_ovf = 0;

  // memory model, ready generation and interrupt counting on falling edges
  always @(negedge clk) begin
    if (irq) irq_count++;
    mem_wready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
    if (mem_wvalid && mem_wready) begin
      if (mem_waddr < BASE_M || mem_waddr - BASE_M >= 64'd2048) bad_addr = 1;
      else mem_model[int'((mem_waddr - BASE_M) >> 2)] = mem_wdata;
      wr_count++;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int w);
    case (w)
      0: return {t_ssid, t_ssv, 3'b000, t_code};
      1: return t_sid;
      2: return {t_stall, 15'd0, t_stag};
      3: return {22'd0, t_cls, t_s2, 3'b000, t_rnw, t_ind, t_pnu, 1'b0};
      4: return t_addr[31:0];
      5: return t_addr[63:32];
      6: return t_addr2[31:0];
      default: return t_addr2[63:32];
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] wbit();
    int l = (cfg_log2size > 8) ? 8 : int'(cfg_log2size);
    return IDX_W'(1) << l;
  endfunction

  task automatic rand_fields();
    t_code = 8'($urandom); t_sid = $urandom; t_ssid = 20'($urandom);
    t_ssv = 1'($urandom); t_stag = 16'($urandom); t_stall = 1'($urandom);
    t_pnu = 1'($urandom); t_ind = 1'($urandom); t_rnw = 1'($urandom);
    t_s2 = 1'($urandom); t_cls = 2'($urandom);
    t_addr = {$urandom, $urandom}; t_addr2 = {$urandom, $urandom};
  endtask

  task automatic write_cons(logic [IDX_W-1:0] v);
    @(negedge clk); cons_wr = 1; cons_wdata = v;
    @(negedge clk); cons_wr = 0;
    m_cons = v & ((wbit() << 1) - 1'b1);
  endtask

  task automatic do_event(string req, bit stall_chk);
    logic [IDX_W-1:0] wb = wbit();
    logic [IDX_W-1:0] wim = (wb << 1) - 1'b1;
    int slot = int'(m_prod & (wb - 1'b1));
    int wr0 = wr_count, irq0 = irq_count;
    bit full = ((m_cons ^ m_prod) & wim) == wb;
    bit writes = queue_en && !full;
    bit irq_exp = writes && irq_en;
    logic [31:0] prod_before = prod_reg;
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    if (stall_chk) hold_ready = 1;
    ev_valid = 1;
    @(negedge clk);
    ev_valid = 0;
    if (stall_chk) begin
      repeat (4) @(negedge clk);
      check(mem_wvalid == 1, "R5", "stalled wvalid", 64'(mem_wvalid), 1);
      check(mem_waddr == BASE_M + 64'(slot * 32), "R5", "stalled word0 address", mem_waddr, BASE_M + 64'(slot * 32));
      check(prod_reg == prod_before, "R6", "producer during record", 64'(prod_reg), 64'(prod_before));
      check(ev_ready == 0, "R11", "ready while busy", 64'(ev_ready), 0);
      hold_ready = 0;
    end
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    if (writes) m_prod = (m_prod + 1'b1) & wim;
    if (queue_en && full) m_ovf = ~m_ovf;
    check(prod_reg == {m_ovf, 22'd0, m_prod}, req, "producer register", 64'(prod_reg), 64'({m_ovf, 22'd0, m_prod}));
    check(wr_count - wr0 == (writes ? 8 : 0), req, "word writes", 64'(wr_count - wr0), writes ? 8 : 0);
    check(irq_count - irq0 == (irq_exp ? 1 : 0), "R9", "irq pulses", 64'(irq_count - irq0), irq_exp ? 1 : 0);
    if (writes) begin
      for (int w = 0; w < 8; w++) begin
        string rq = (w < 2) ? "R2" : (w < 4) ? "R3" : "R4";
        check(mem_model[slot * 8 + w] == exp_word(w), rq, $sformatf("slot %0d word %0d (R5 placement)", slot, w),
              64'(mem_model[slot * 8 + w]), 64'(exp_word(w)));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 512; i++) mem_model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(prod_reg == 0, "R1", "reset producer", 64'(prod_reg), 0);
    check(irq == 0, "R1", "reset irq", 64'(irq), 0);
    check(mem_wvalid == 0, "R1", "reset wvalid", 64'(mem_wvalid), 0);
    check(ev_ready == 1, "R1", "reset ready", 64'(ev_ready), 1);

    queue_en = 1; irq_en = 1; cfg_log2size = 4'd2;
    rand_fields(); do_event("R6", 1);
    for (int i = 0; i < 3; i++) begin rand_fields(); do_event("R6", 0); end
    // ring of 4 now full: two drops toggle the flag twice
    rand_fields(); do_event("R7", 0);
    check(prod_reg[31] == 1, "R7", "overflow flag set", 64'(prod_reg[31]), 1);
    rand_fields(); do_event("R7", 0);
    write_cons(9'd1);
    rand_fields(); do_event("R10", 0);
    irq_en = 0; write_cons(m_prod);
    rand_fields(); do_event("R9", 0);
    queue_en = 0;
    rand_fields(); do_event("R8", 0);
    queue_en = 1; irq_en = 1;
    cfg_log2size = 4'd15;  // clamped to 8
    write_cons(m_prod);
    rand_fields(); do_event("R12", 0);
    check(bad_addr == 0, "R12", "address window after clamp", 64'(bad_addr), 0);

    cfg_log2size = 4'd3; write_cons(m_prod);
    for (int i = 0; i < 40; i++) begin
      if (($urandom % 3) == 0) write_cons(m_prod);
      irq_en = 1'($urandom);
      rand_fields();
      if (i % 7 == 3) begin t_code = 8'h24; t_addr = '1; t_addr2 = '0; end
      do_event("R6", 0);
    end
    check(bad_addr == 0, "R5", "all writes inside ring", 64'(bad_addr), 0);
    finish_run();
  end
endmodule